// File: doc/BRIEF.md
# Output Sample Framer with Time-Break Flag

This block sits after a decimation filter. Each 24-bit sample that the filter delivers is stored together with an 8-bit status byte in an eight-entry FIFO. Whenever the FIFO holds anything and the serial shifter is idle, the oldest entry moves into the shifter and goes out on a one-wire serial link, MSB first. A framing signal stays high for the whole word.

Transfers need no request. The word is 32 bits (status byte first) or 24 bits (sample only), chosen by a format input at the moment the word is loaded. A serial bit-enable pulse, synchronous to the system clock, advances the shifter by one bit. A time-break strobe is latched and reported in the status of the sample that closes the interval in which the strobe fell.

If the FIFO is full, an incoming sample is dropped. The next sample that is stored reports the loss.

Top module: `sample_framer`

## Requirements
- R1: While and right after reset, `sframe`, `sdo` and `drdy` are 0 and the FIFO is empty.
- R2: A stored entry is {status[7:0], sample[23:0]}. Status bit 7 is the time-break flag, bit 6 is the overflow flag, bits 5:3 are 0, and bits 2:0 are the sequence count.
- R3: The FIFO holds up to 8 entries. `drdy` is 1 exactly when at least one entry is stored and not yet moved to the shifter.
- R4: When the shifter is idle and the FIFO is not empty, the oldest entry is loaded and `sframe` rises on the following clock edge. No request is needed.
- R5: `fmt_full` is sampled at load time. When it is 1, the frame lasts 32 `sclk_en` pulses. When it is 0, the frame lasts 24 pulses and sends only the sample. `sframe` falls at the edge where the last pulse is taken.
- R6: Bits leave MSB first, and the status byte comes first in the 32-bit format. Bit k is on `sdo` from the k-th `sclk_en` pulse of the frame until the next pulse; bit 0 is on `sdo` from the load until the first pulse.
- R7: A strobe on `tbrk` sets bit 7 of the next stored sample. A strobe in the same cycle as `smp_valid` is credited to the sample after that one.
- R8: The time-break flag clears when it is attached to a stored sample. It stays pending across a dropped sample.
- R9: A sample that arrives while 8 entries are stored is dropped. The sticky overflow flag is then reported in bit 6 of the next stored entry and clears when that entry is stored. Fullness is judged on the occupancy before the edge.
- R10: The sequence count increments by one per stored entry and wraps modulo 8. Dropped samples do not advance it.
- R11: `sdo` is 0 whenever `sframe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 24 | Filtered sample |
| smp_valid | input | 1 | One-cycle sample strobe |
| tbrk | input | 1 | Time-break strobe |
| fmt_full | input | 1 | 1: status plus data, 0: data only |
| sclk_en | input | 1 | Serial bit-advance pulse |
| sdo | output | 1 | Serial data |
| sframe | output | 1 | High for the duration of a word |
| drdy | output | 1 | FIFO holds at least one entry |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a sample store and a time-break strobe. The second is a FIFO push and a pop into the shifter, and a full FIFO adds a dropped sample to that pair. The stimulus drives `smp_valid` and `tbrk` at random points, with a directed stretch that raises both together. Slow `sclk_en` rates make the FIFO fill while a word is leaving, so pushes, pops and drops collide. A behavioural queue model in the bench rebuilds every status byte and every serial bit on each clock, and a wrongly credited flag or a misordered push and pop shows up as a mismatch on `sdo`, `sframe` or `drdy`.

// File: rtl/sample_framer.sv
module sample_framer #(
  parameter int DEPTH = 8,
  parameter int SW    = 24,
  parameter int STW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp_data,
  input  logic          smp_valid,
  input  logic          tbrk,
  input  logic          fmt_full,
  input  logic          sclk_en,
  output logic          sdo,
  output logic          sframe,
  output logic          drdy
);
  localparam int EW = SW + STW;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(EW);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used;
  logic          tb_pend, ovf_pend;
  logic [2:0]    seq;
  logic          busy;
  logic [EW-1:0] shreg;
  logic [BW-1:0] bit_idx, last_idx;

  wire full = (used == CW'(DEPTH));
  wire push = smp_valid && !full;
  wire pop  = !busy && (used != '0);
  wire [STW-1:0] status = {tb_pend, ovf_pend, {(STW-5){1'b0}}, seq};
  wire [EW-1:0] head = mem[rd_ptr];

  assign sframe = busy;
  assign sdo    = busy & shreg[EW-1];
  assign drdy   = (used != '0);

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {status, smp_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tb_pend  <= 1'b0;
      ovf_pend <= 1'b0;
      seq      <= '0;
    end else if (push) begin
      tb_pend  <= tbrk;
      ovf_pend <= 1'b0;
      seq      <= seq + 1'b1;
    end else begin
      tb_pend  <= tb_pend | tbrk;
      ovf_pend <= ovf_pend | smp_valid;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
    end else if (pop) begin
      busy     <= 1'b1;
      bit_idx  <= '0;
      last_idx <= fmt_full ? BW'(EW-1) : BW'(SW-1);
      shreg    <= fmt_full ? head : {head[SW-1:0], {STW{1'b0}}};
    end else if (busy && sclk_en) begin
      if (bit_idx == last_idx) busy <= 1'b0;
      else begin
        shreg   <= shreg << 1;
        bit_idx <= bit_idx + 1'b1;
      end
    end
endmodule

// File: rtl/sample_framer_chk.sv
module sample_framer_chk #(parameter int CW = 4, parameter int DEPTH = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          tbrk,
  input logic          sclk_en,
  input logic          sdo,
  input logic          sframe,
  input logic          drdy,
  input logic          full,
  input logic          tb_pend,
  input logic [CW-1:0] used
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sframe |-> !sdo); // R11
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sframe && $past(sframe) && !$past(sclk_en) |-> $stable(sdo)); // R6
  AST_AUTO_START: assert property (@(posedge clk) disable iff (!rst_n) !sframe && drdy |=> sframe); // R4
  AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(sframe) |-> $past(drdy)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) used <= CW'(DEPTH)); // R3
  AST_TB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !full && !tbrk |=> !tb_pend); // R8
  AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tbrk |=> tb_pend); // R7
endmodule

bind sample_framer sample_framer_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .tbrk(tbrk), .sclk_en(sclk_en),
  .sdo(sdo), .sframe(sframe), .drdy(drdy), .full(full), .tb_pend(tb_pend), .used(used));

// File: tb/sim_sample_framer.sv
module sim_sample_framer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] smp_data = '0;
  logic smp_valid = 1'b0, tbrk = 1'b0, fmt_full = 1'b1, sclk_en = 1'b0;
  logic sdo, sframe, drdy;
  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sample_framer u0 (.clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .tbrk(tbrk), .fmt_full(fmt_full), .sclk_en(sclk_en), .sdo(sdo), .sframe(sframe), .drdy(drdy));

  // behavioural reference model
  logic [31:0] q[$];
  bit m_tb, m_ovf, m_busy;
  int m_seq, m_cnt, m_nb;
  logic [31:0] m_sh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_tb = 0; m_ovf = 0; m_busy = 0; m_seq = 0; m_cnt = 0; m_nb = 32; m_sh = '0;
    end else begin
      bit was_full, was_busy;
      was_full = (q.size() == 8);
      was_busy = m_busy;
      if (was_busy && sclk_en) begin
        if (m_cnt == m_nb - 1) m_busy = 0;
        else begin m_sh = m_sh << 1; m_cnt++; end
      end
      if (!was_busy && q.size() != 0) begin
        logic [31:0] e;
        e = q.pop_front();
        m_sh = fmt_full ? e : {e[23:0], 8'h00};
        m_nb = fmt_full ? 32 : 24;
        m_cnt = 0; m_busy = 1;
      end
      if (smp_valid && !was_full) begin
        q.push_back({m_tb, m_ovf, 3'b000, 3'(m_seq), smp_data});
        m_seq = (m_seq + 1) % 8; m_tb = tbrk; m_ovf = 0;
      end else begin
        m_tb = m_tb | tbrk;
        if (smp_valid) m_ovf = 1;
      end
    end
  end

  task automatic cmp(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp(sframe, m_busy, "sframe");
    cmp(sdo, m_busy & m_sh[31], "sdo");
    cmp(drdy, q.size() != 0, "drdy");
  endtask

  // drive and compare at the falling edge
  task automatic run(input int n, input int div, input int pv, input int pt, input int fmt_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      smp_valid = ($urandom_range(99) < pv);
      smp_data  = 24'($urandom);
      tbrk      = ($urandom_range(99) < pt);
      sclk_en   = (div <= 1) ? 1'b1 : ($urandom_range(div - 1) == 0);
      if (fmt_mode == 2) fmt_full = $urandom_range(1);
      else fmt_full = fmt_mode[0];
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    cmp(sframe, 1'b0, "reset sframe");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    cur_req = "R2"; run(1500, 1, 3, 2, 1);   // status plus data, steady drain
    cur_req = "R5"; run(1500, 1, 3, 2, 0);   // data-only words
    cur_req = "R6"; run(2000, 4, 2, 2, 2);   // mixed formats, slow bit rate
    cur_req = "R7"; run(2000, 2, 30, 30, 2); // strobes and samples often together
    cur_req = "R8"; run(1000, 1, 50, 60, 1);
    cur_req = "R9"; run(3000, 8, 40, 10, 1); // FIFO fills, samples dropped
    cur_req = "R3"; run(1500, 3, 10, 5, 0);
    cur_req = "R10"; run(2000, 1, 5, 5, 2);
    cur_req = "R4"; run(1500, 1, 1, 1, 1);
    cur_req = "R11"; run(500, 2, 0, 0, 1);   // drain to idle
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule